// File: doc/BRIEF.md
# Sparse Associative Memory Model

This block behaves like a multi-port memory with a large address space while keeping storage only for the locations that have actually been touched. It holds an ordered table of address/data entries, up to a fixed capacity. The entry nearest the tail has the highest priority, so a later entry for an address hides any earlier one. Write ports append at the tail. A read port returns the newest matching entry. A read of a location never seen before invents an "initial content" value from a pseudo-random source, stores it at the head of the table and returns it, so every later read of that location sees the same value until it is written.

Accesses start on a rising edge of a port enable, never on a level. All edges are captured together with the port's address and data. A sequencer then serves one captured access per clock, in a fixed port order. The clean-up option removes stale entries for an address before a write appends its new entry, one entry per clock. A `busy` output covers the whole time that any captured access is outstanding. `full` reports that every table slot is in use. `overflow` latches the first insertion that had to be dropped because the table was full.

Top module: `sparse_assoc_mem`

## Requirements
- R1: After synchronous reset, `busy`, `full` and `overflow` are 0, every read data output is 0, and the table is empty.
- R2: An access is triggered only by a 0-to-1 change of a port enable. Address and data are taken in the cycle of that rise. Holding the enable high starts no further access, and input changes made while it stays high are ignored.
- R3: A read of an address that has been written returns the data of the most recent write to that address.
- R4: A read that finds no entry for its address returns bits [DATA_W-1:0] of a 32-bit shift register and then advances that register. The register resets to 0xACE12B5D and advances as `next = (s >> 1) ^ (s[0] ? 0x80200003 : 0)`. The returned value is stored at the head of the table, so a repeated read of that address returns the same value.
- R5: A write to an address that was allocated by a read miss overrides the allocated value for all later reads.
- R6: Accesses captured in the same cycle are served one per clock in a fixed order: write ports by ascending index first, then read ports by ascending index. A read in the same cycle as a write to the same address therefore returns the new data, and of two writes to one address in one cycle the higher-indexed port wins.
- R7: A read port's data output changes only in the clock that serves that port's own access. Otherwise it holds its value.
- R8: With clean-up enabled, a write first removes every older entry of its address, one per clock, and then appends. Rewriting an existing address therefore never uses more capacity, even when the table is full.
- R9: `full` is 1 exactly when all DEPTH entries are in use. An insertion attempted while full is dropped and sets `overflow`, which stays 1 until reset. A read miss while full still returns and consumes a fresh value but stores nothing.
- R10: `busy` is 1 from the clock after an enable rise until the clock in which the last outstanding access completes. While `busy` is 0 the table does not change. A single read that hits keeps `busy` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NWR | Write-port enables; a rising edge starts a write |
| wr_addr | input | NWR*ADDR_W | Write addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | NWR*DATA_W | Write data, port i at bits [i*DATA_W +: DATA_W] |
| rd_en | input | NRD | Read-port enables; a rising edge starts a read |
| rd_addr | input | NRD*ADDR_W | Read addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| rd_data | output | NRD*DATA_W | Registered read results, port i at bits [i*DATA_W +: DATA_W] |
| busy | output | 1 | Captured accesses are still outstanding |
| full | output | 1 | All table entries are in use |
| overflow | output | 1 | Sticky: an insertion was dropped for lack of space |

## Verification
The hardest state to reach from the ports is a full table. In that state three things must be seen to differ: a clean-up rewrite that still fits, a dropped new write that sets the sticky flag, and a read miss that returns fresh values without storing them. The bench resets the block in the middle of the run with a small capacity. It rewrites one address several times, fills the remaining slots with distinct addresses, and then issues the rewrite, the dropped write and two misses in turn. Same-cycle collisions are produced by raising several enables on one falling edge. A behavioural model built on queues is compared against every output on every clock, so that the order of deletion, append and head-insert cycles is checked together with the final values.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    TBL_IDLE   = 2'd0,
    TBL_DELETE = 2'd1,
    TBL_APPEND = 2'd2,
    TBL_HEAD   = 2'd3
  } tbl_cmd_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsr_advance(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction
endpackage

// File: rtl/sam_port_capture.sv
module sam_port_capture #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] payload,
  input  logic          clr,
  output logic          pend,
  output logic [PW-1:0] held
);
  logic en_q;
  logic rise;

  assign rise = en & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      en_q <= en;
      pend <= (pend & ~clr) | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rise) held <= payload;
  end
endmodule

// File: rtl/sam_arbiter.sv
module sam_arbiter #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/sam_lfsr.sv
module sam_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2B5D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [31:0] state
);
  import sam_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= lfsr_advance(state);
  end
endmodule

// File: rtl/sam_table.sv
module sam_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  sam_pkg::tbl_cmd_e cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic [IDX_W-1:0]  first_idx,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  import sam_pkg::*;

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  match;

  // match vector over occupied slots
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = (CNT_W'(g) < count) && (ent_addr[g] == lk_addr);
    end
  endgenerate

  // newest match wins for data; oldest match is the clean-up victim
  always_comb begin
    hit_data  = '0;
    first_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_data = ent_data[i];
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) first_idx = IDX_W'(i);
    end
    hit = |match;
  end

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case (cmd)
        TBL_DELETE:            count <= count - CNT_W'(1);
        TBL_APPEND, TBL_HEAD:  count <= count + CNT_W'(1);
        default:               count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (cmd)
      TBL_DELETE: begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IDX_W'(i) >= first_idx) begin
            ent_addr[i] <= ent_addr[i+1];
            ent_data[i] <= ent_data[i+1];
          end
        end
      end
      TBL_APPEND: begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CNT_W'(i) == count) begin
            ent_addr[i] <= cmd_addr;
            ent_data[i] <= cmd_data;
          end
        end
      end
      TBL_HEAD: begin
        for (int i = 1; i < DEPTH; i++) begin
          ent_addr[i] <= ent_addr[i-1];
          ent_data[i] <= ent_data[i-1];
        end
        ent_addr[0] <= cmd_addr;
        ent_data[0] <= cmd_data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sparse_assoc_mem.sv
module sparse_assoc_mem #(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 16,
  parameter int          DEPTH   = 8,
  parameter int          NWR     = 2,
  parameter int          NRD     = 2,
  parameter int          CLEANUP = 1,
  parameter logic [31:0] SEED    = 32'hACE1_2B5D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR*ADDR_W-1:0]   wr_addr,
  input  logic [NWR*DATA_W-1:0]   wr_data,
  input  logic [NRD-1:0]          rd_en,
  input  logic [NRD*ADDR_W-1:0]   rd_addr,
  output logic [NRD*DATA_W-1:0]   rd_data,
  output logic                    busy,
  output logic                    full,
  output logic                    overflow
);
  import sam_pkg::*;

  localparam int NP    = NWR + NRD;
  localparam int PW    = ADDR_W + DATA_W;
  localparam int SELW  = (NP > 1) ? $clog2(NP) : 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NP-1:0]     pend;
  logic [NP-1:0]     clr;
  logic [PW-1:0]     held [NP];
  logic [SELW-1:0]   sel;
  logic              any;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic              is_wr;
  tbl_cmd_e          cmd;
  logic              hit;
  logic [DATA_W-1:0] hit_data;
  logic [IDX_W-1:0]  first_idx;
  logic [CNT_W-1:0]  tbl_count;
  logic              tbl_full;
  logic [31:0]       lfsr_q;
  logic              lfsr_step;
  logic              done;
  logic              ovf_set;
  logic [NRD-1:0]    rd_load;
  logic [DATA_W-1:0] rd_val;

  // per-port edge capture
  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      if (p < NWR) begin : g_wr
        sam_port_capture #(.PW(PW)) u_cap (
          .clk(clk), .rst(rst), .en(wr_en[p]),
          .payload({wr_addr[p*ADDR_W +: ADDR_W], wr_data[p*DATA_W +: DATA_W]}),
          .clr(clr[p]), .pend(pend[p]), .held(held[p])
        );
      end else begin : g_rd
        sam_port_capture #(.PW(PW)) u_cap (
          .clk(clk), .rst(rst), .en(rd_en[p-NWR]),
          .payload({rd_addr[(p-NWR)*ADDR_W +: ADDR_W], {DATA_W{1'b0}}}),
          .clr(clr[p]), .pend(pend[p]), .held(held[p])
        );
      end
    end
  endgenerate

  sam_arbiter #(.N(NP)) u_arb (.req(pend), .idx(sel), .any(any));

  assign cur_addr = held[sel][PW-1:DATA_W];
  assign cur_data = held[sel][DATA_W-1:0];
  assign is_wr    = (int'(sel) < NWR);

  sam_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_tbl (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_addr(cur_addr),
    .cmd_data(lfsr_step ? lfsr_q[DATA_W-1:0] : cur_data),
    .lk_addr(cur_addr), .hit(hit), .hit_data(hit_data),
    .first_idx(first_idx), .count(tbl_count), .full(tbl_full)
  );

  sam_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .step(lfsr_step), .state(lfsr_q));

  // sequencer: one captured access (or one clean-up delete) per clock
  always_comb begin
    cmd       = TBL_IDLE;
    done      = 1'b0;
    ovf_set   = 1'b0;
    lfsr_step = 1'b0;
    rd_val    = hit_data;
    if (any) begin
      if (is_wr) begin
        if ((CLEANUP != 0) && hit) begin
          cmd = TBL_DELETE;
        end else begin
          done = 1'b1;
          if (tbl_full) ovf_set = 1'b1;
          else          cmd     = TBL_APPEND;
        end
      end else begin
        done = 1'b1;
        if (!hit) begin
          rd_val    = lfsr_q[DATA_W-1:0];
          lfsr_step = 1'b1;
          if (tbl_full) ovf_set = 1'b1;
          else          cmd     = TBL_HEAD;
        end
      end
    end
    for (int p = 0; p < NP; p++) clr[p] = done && (sel == SELW'(p));
    for (int r = 0; r < NRD; r++) rd_load[r] = done && (sel == SELW'(NWR + r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      overflow <= 1'b0;
    end else begin
      for (int r = 0; r < NRD; r++) begin
        if (rd_load[r]) rd_data[r*DATA_W +: DATA_W] <= rd_val;
      end
      if (ovf_set) overflow <= 1'b1;
    end
  end

  assign busy = |pend;
  assign full = tbl_full;
endmodule

// File: rtl/sparse_assoc_mem_chk.sv
module sparse_assoc_mem_chk #(
  parameter int DEPTH  = 8,
  parameter int NRD    = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  full,
  input logic                  overflow,
  input logic [NRD*DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]      cnt
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(full)); // R9
  AST_IDLE_TABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(cnt)); // R10
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)) || (cnt + CNT_W'(1) == $past(cnt))); // R6
endmodule

bind sparse_assoc_mem sparse_assoc_mem_chk #(
  .DEPTH(DEPTH), .NRD(NRD), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .full(full),
  .overflow(overflow), .rd_data(rd_data), .cnt(tbl_count)
);

// File: tb/sparse_assoc_mem_bench.sv
module sparse_assoc_mem_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DP = 4;
  localparam int NW = 2;
  localparam int NR = 2;
  localparam int NP = NW + NR;
  localparam logic [31:0] SEED = 32'hACE1_2B5D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR-1:0]    rd_en = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;
  logic busy, full, overflow;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sparse_assoc_mem #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .NWR(NW), .NRD(NR),
                     .CLEANUP(1), .SEED(SEED)) u_sparse_assoc_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .full(full), .overflow(overflow)
  );

  // ---------------- reference model ----------------
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  bit            m_pend [NP];
  bit            m_prev [NP];
  logic [AW-1:0] m_ca   [NP];
  logic [DW-1:0] m_cd   [NP];
  logic [DW-1:0] m_rd   [NR];
  logic [31:0]   m_lfsr;
  bit            m_ovf;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ 32'h8020_0003;
    return n;
  endfunction

  task automatic model_reset();
    qa.delete(); qd.delete();
    for (int i = 0; i < NP; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
    for (int i = 0; i < NR; i++) m_rd[i] = '0;
    m_lfsr = SEED;
    m_ovf = 0;
  endtask

  task automatic model_step();
    int p;
    p = -1;
    for (int i = 0; i < NP; i++) if (m_pend[i] && p < 0) p = i;
    if (p >= 0) begin
      if (p < NW) begin
        int f;
        f = -1;
        for (int i = 0; i < qa.size(); i++) if (qa[i] == m_ca[p] && f < 0) f = i;
        if (f >= 0) begin
          qa.delete(f); qd.delete(f);
        end else begin
          m_pend[p] = 0;
          if (qa.size() == DP) m_ovf = 1;
          else begin qa.push_back(m_ca[p]); qd.push_back(m_cd[p]); end
        end
      end else begin
        int l;
        l = -1;
        for (int i = 0; i < qa.size(); i++) if (qa[i] == m_ca[p]) l = i;
        m_pend[p] = 0;
        if (l >= 0) m_rd[p-NW] = qd[l];
        else begin
          m_rd[p-NW] = m_lfsr[DW-1:0];
          if (qa.size() == DP) m_ovf = 1;
          else begin qa.push_front(m_ca[p]); qd.push_front(m_lfsr[DW-1:0]); end
          m_lfsr = nxt(m_lfsr);
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      bit e;
      e = (i < NW) ? wr_en[i] : rd_en[i-NW];
      if (e && !m_prev[i]) begin
        m_pend[i] = 1;
        if (i < NW) begin
          m_ca[i] = wr_addr[i*AW +: AW];
          m_cd[i] = wr_data[i*DW +: DW];
        end else begin
          m_ca[i] = rd_addr[(i-NW)*AW +: AW];
          m_cd[i] = '0;
        end
      end
      m_prev[i] = e;
    end
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else     model_step();
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit mb;
      mb = 0;
      for (int i = 0; i < NP; i++) mb |= m_pend[i];
      chk("R10", "busy", 32'(busy), 32'(mb));
      chk("R9", "full", 32'(full), 32'(qa.size() == DP));
      chk("R9", "overflow", 32'(overflow), 32'(m_ovf));
      for (int r = 0; r < NR; r++)
        chk("R7", "rd_data", 32'(rd_data[r*DW +: DW]), 32'(m_rd[r]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic setw(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_addr[p*AW +: AW] = a;
    wr_data[p*DW +: DW] = d;
  endtask

  task automatic setr(input int p, input logic [AW-1:0] a);
    rd_addr[p*AW +: AW] = a;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 50 && busy; n++) @(negedge clk);
  endtask

  task automatic pulse(input logic [NW-1:0] wm, input logic [NR-1:0] rm);
    @(negedge clk);
    wr_en = wm; rd_en = rm;
    @(negedge clk);
    wr_en = '0; rd_en = '0;
    wait_idle();
  endtask

  function automatic logic [31:0] rdp(input int r);
    return 32'(rd_data[r*DW +: DW]);
  endfunction

  initial begin
    logic [31:0] s1;
    s1 = nxt(SEED);
    repeat (3) @(negedge clk);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "full", 32'(full), 0);
    chk("R1", "overflow", 32'(overflow), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);
    rst = 1'b0;

    // R3: write then read
    setw(0, 8'd5, 16'h1111); pulse(2'b01, 2'b00);
    setr(0, 8'd5); pulse(2'b00, 2'b01);
    chk("R3", "read after write", rdp(0), 32'h1111);

    // R4: miss returns seed value, repeat read agrees
    setr(1, 8'd9); pulse(2'b00, 2'b10);
    chk("R4", "miss value", rdp(1), 32'(SEED[DW-1:0]));
    setr(0, 8'd9); pulse(2'b00, 2'b01);
    chk("R4", "repeat read", rdp(0), 32'(SEED[DW-1:0]));

    // R5: write overrides allocated value
    setw(1, 8'd9, 16'h2222); pulse(2'b10, 2'b00);
    setr(1, 8'd9); pulse(2'b00, 2'b10);
    chk("R5", "override miss", rdp(1), 32'h2222);

    // R6: same-cycle write and read, and two writes to one address
    setw(0, 8'd20, 16'h3333); setr(0, 8'd20); pulse(2'b01, 2'b01);
    chk("R6", "read sees same-cycle write", rdp(0), 32'h3333);
    setw(0, 8'd30, 16'h4444); setw(1, 8'd30, 16'h5555); pulse(2'b11, 2'b00);
    setr(1, 8'd30); pulse(2'b00, 2'b10);
    chk("R6", "higher write port wins", rdp(1), 32'h5555);

    // R7: other port's read leaves port 0 unchanged
    setr(1, 8'd5); pulse(2'b00, 2'b10);
    chk("R7", "port0 held", rdp(0), 32'h3333);
    chk("R7", "port1 updated", rdp(1), 32'h1111);

    // R2: holding enable high triggers once
    setw(0, 8'd5, 16'hAAAA);
    @(negedge clk); wr_en = 2'b01;
    repeat (3) @(negedge clk);
    setw(0, 8'd5, 16'hBBBB);
    repeat (3) @(negedge clk);
    wr_en = '0; wait_idle();
    setr(0, 8'd5); pulse(2'b00, 2'b01);
    chk("R2", "level ignored", rdp(0), 32'hAAAA);

    // R10: single hit keeps busy one cycle
    setr(1, 8'd20);
    @(negedge clk); rd_en = 2'b10;
    @(negedge clk); rd_en = '0;
    chk("R10", "busy during read", 32'(busy), 1);
    @(negedge clk);
    chk("R10", "busy after read", 32'(busy), 0);
    chk("R10", "read value", rdp(1), 32'h3333);

    // capacity phase from a fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    setw(0, 8'd1, 16'h0A01); pulse(2'b01, 2'b00);
    setw(0, 8'd1, 16'h0A02); pulse(2'b01, 2'b00);
    setw(0, 8'd1, 16'h0A03); pulse(2'b01, 2'b00);
    setw(0, 8'd2, 16'h0B00); pulse(2'b01, 2'b00);
    setw(0, 8'd3, 16'h0C00); pulse(2'b01, 2'b00);
    chk("R8", "rewrites use no capacity", 32'(full), 0);
    setw(0, 8'd4, 16'h0D00); pulse(2'b01, 2'b00);
    chk("R9", "full at depth", 32'(full), 1);
    chk("R9", "no overflow yet", 32'(overflow), 0);
    setw(1, 8'd2, 16'h7777); pulse(2'b10, 2'b00);
    chk("R8", "rewrite when full", 32'(overflow), 0);
    setr(0, 8'd2); pulse(2'b00, 2'b01);
    chk("R8", "rewrite data", rdp(0), 32'h7777);
    setw(0, 8'd5, 16'h0E00); pulse(2'b01, 2'b00);
    chk("R9", "overflow on drop", 32'(overflow), 1);
    setr(0, 8'd5); pulse(2'b00, 2'b01);
    chk("R9", "miss when full", rdp(0), 32'(SEED[DW-1:0]));
    setr(0, 8'd5); pulse(2'b00, 2'b01);
    chk("R9", "miss not stored", rdp(0), 32'(s1[DW-1:0]));
    chk("R9", "overflow sticky", 32'(overflow), 1);
    setr(1, 8'd1); pulse(2'b00, 2'b10);
    chk("R8", "latest of rewrites", rdp(1), 32'h0A03);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule